// File: doc/BRIEF.md
# Card Data FIFO Engine

This block sits between a word-oriented host register window and a byte-wide card data port. It holds up to sixteen 32-bit words in a circular buffer. In the receive direction it gathers card bytes into words. In the transmit direction it breaks words back into bytes. A remaining-byte counter, loaded from a programmed length when the engine starts, decides when the transfer is over. The block drops its own busy flag once the counter is exhausted and the buffer has drained.

The host starts a transfer with a one-cycle control write that carries the run bit, the direction and the length. It then feeds words in (transmit) or takes words out (receive). The card side moves at most one byte per clock through a valid/ready handshake. A group of five occupancy flags is published for whichever direction is active, and the group for the other direction reads zero.

Top module: `card_fifo_engine`

## Requirements
- R1: The buffer keeps word order and holds at most 16 words. `host_rdata_o` always shows the oldest word, or zero when the buffer is empty. A host pop takes effect only in the receive direction and only when the buffer is non-empty.
- R2: In the receive direction, card bytes fill a word starting at bits 7:0 and moving upward. The word is stored after 4 bytes, or earlier with its upper bytes zero when the last byte of the transfer arrives.
- R3: `crd_rx_ready_o` is high only while the engine is busy in the receive direction, bytes remain and the buffer holds fewer than 16 words.
- R4: In the transmit direction, each stored word is sent to the card least-significant byte first. `crd_tx_valid_o` is high while bytes remain and either a partly sent word or a stored word is available. Unsent bytes of the final word are discarded when the count runs out.
- R5: A control write with `ctrl_en_i`=1 loads `len_i` into `remain_o`. Each card byte handshake lowers it by one.
- R6: `data_end_o` and `block_end_o` become 1 once the engine is busy with zero bytes remaining. They stay set until the next start.
- R7: When the engine is busy with zero bytes remaining and an empty buffer, `busy_o` falls on the next edge. Both flag groups then read zero.
- R8: The flag encoding is bit0 active, bit1 threshold, bit2 full (16 words), bit3 empty (0 words) and bit4 data available (non-zero count). The transmit threshold means 8 or fewer words. The receive threshold means 8 or more words.
- R9: `tx_flags_o` is non-zero only in the transmit direction (`ctrl_rx_i`=0). `rx_flags_o` is non-zero only in the receive direction.
- R10: A host push is ignored unless the engine is busy, transmitting and has bytes remaining.
- R11: A push into a full buffer is dropped, leaving the stored words intact. It sets the sticky `ovf_o`.
- R12: A control write with `ctrl_en_i`=0 stops the engine. Card handshakes stop and `remain_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr_i | input | 1 | One-cycle control write strobe |
| ctrl_en_i | input | 1 | Run bit of the control write |
| ctrl_rx_i | input | 1 | Direction: 1 card-to-host, 0 host-to-card |
| len_i | input | 16 | Transfer length in bytes |
| host_push_i | input | 1 | Host word write |
| host_wdata_i | input | 32 | Host word to store |
| host_pop_i | input | 1 | Host word read |
| host_rdata_o | output | 32 | Oldest stored word, zero when empty |
| crd_rx_valid_i | input | 1 | Card has a byte ready |
| crd_rx_byte_i | input | 8 | Byte from the card |
| crd_rx_ready_o | output | 1 | Engine accepts the card byte |
| crd_tx_valid_o | output | 1 | Engine offers a byte to the card |
| crd_tx_byte_o | output | 8 | Byte for the card |
| crd_tx_ready_i | input | 1 | Card takes the byte |
| busy_o | output | 1 | Engine enabled |
| remain_o | output | 16 | Bytes still to move |
| data_end_o | output | 1 | Transfer count reached zero |
| block_end_o | output | 1 | Block finished (set with data end) |
| tx_flags_o | output | 5 | Transmit occupancy flags |
| rx_flags_o | output | 5 | Receive occupancy flags |
| ovf_o | output | 1 | Sticky dropped-push indicator |

## Verification
The assertions take four things for granted about the inputs. A control write is not combined with host traffic in the same cycle. Host pushes are meant for transmit and host pops for receive. Card bytes move only through the handshake. The stimulus drives every control write in a cycle of its own. It pushes only during transmit runs and pops only during receive runs, apart from the deliberate idle push and empty pop. The one overflowing push is confined to the final directed case, so the sticky error cannot mask later runs.

// File: rtl/cfe_pkg.sv
package cfe_pkg;
  localparam int FLAG_W  = 5;
  localparam int FL_ACT  = 0;
  localparam int FL_THR  = 1;
  localparam int FL_FULL = 2;
  localparam int FL_EMP  = 3;
  localparam int FL_AVL  = 4;
endpackage

// File: rtl/cfe_word_fifo.sv
module cfe_word_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          drop_o
);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rptr_q, rptr_d, wslot;
  logic [CW-1:0] count_q, count_d;
  logic          do_push, do_pop;

  assign full_o  = (count_q == FULL_C);
  assign empty_o = (count_q == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign drop_o  = push_i & full_o;
  assign wslot   = rptr_q + count_q[AW-1:0];
  assign rdata_o = empty_o ? '0 : mem[rptr_q];
  assign count_o = count_q;

  always_comb begin
    rptr_d  = rptr_q;
    count_d = count_q;
    if (do_pop) rptr_d = rptr_q + AW'(1);
    case ({do_push, do_pop})
      2'b10:   count_d = count_q + CW'(1);
      2'b01:   count_d = count_q - CW'(1);
      default: count_d = count_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      rptr_q  <= rptr_d;
      count_q <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wslot] <= wdata_i;
  end

  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= FULL_C);
  p_drop_keeps_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full_o && !pop_i) |=> (count_q == $past(count_q) && rptr_q == $past(rptr_q)));
endmodule

// File: rtl/cfe_rx_packer.sv
module cfe_rx_packer #(
  parameter int W      = 32,
  localparam int BYTES = W / 8,
  localparam int IW    = $clog2(BYTES)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         take_i,
  input  logic         last_i,
  input  logic [7:0]   byte_i,
  output logic         push_o,
  output logic [W-1:0] word_o
);
  localparam logic [IW-1:0] TOP_IDX = IW'(BYTES - 1);

  logic [IW-1:0] idx_q, idx_d;
  logic [W-1:0]  acc_q, acc_d, merged;

  always_comb begin
    merged = acc_q;
    merged[8*idx_q +: 8] = byte_i;
  end

  assign push_o = take_i & ((idx_q == TOP_IDX) | last_i);
  assign word_o = merged;

  always_comb begin
    idx_d = idx_q;
    acc_d = acc_q;
    if (clr_i) begin
      idx_d = '0;
      acc_d = '0;
    end else if (take_i) begin
      if (push_o) begin
        idx_d = '0;
        acc_d = '0;
      end else begin
        idx_d = idx_q + IW'(1);
        acc_d = merged;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      acc_q <= '0;
    end else begin
      idx_q <= idx_d;
      acc_q <= acc_d;
    end
  end

  p_word_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |=> (idx_q == '0 && acc_q == '0));
endmodule

// File: rtl/cfe_tx_unpacker.sv
module cfe_tx_unpacker #(
  parameter int W      = 32,
  localparam int BYTES = W / 8,
  localparam int IW    = $clog2(BYTES)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         take_i,
  input  logic [W-1:0] head_i,
  output logic         pop_o,
  output logic         holding_o,
  output logic [7:0]   byte_o
);
  logic [IW-1:0] left_q, left_d;
  logic [W-1:0]  sh_q, sh_d;

  assign holding_o = (left_q != '0);
  assign byte_o    = holding_o ? sh_q[7:0] : head_i[7:0];
  assign pop_o     = take_i & ~holding_o;

  always_comb begin
    left_d = left_q;
    sh_d   = sh_q;
    if (clr_i) begin
      left_d = '0;
      sh_d   = '0;
    end else if (take_i) begin
      if (holding_o) begin
        left_d = left_q - IW'(1);
        sh_d   = sh_q >> 8;
      end else begin
        left_d = IW'(BYTES - 1);
        sh_d   = head_i >> 8;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      sh_q   <= '0;
    end else begin
      left_q <= left_d;
      sh_q   <= sh_d;
    end
  end

  p_shift_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && holding_o && !clr_i) |=> (sh_q[7:0] == $past(sh_q[15:8])));
endmodule

// File: rtl/cfe_flag_gen.sv
module cfe_flag_gen
  import cfe_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0]     count_i,
  input  logic              live_i,
  input  logic              dir_rx_i,
  output logic [FLAG_W-1:0] tx_o,
  output logic [FLAG_W-1:0] rx_o
);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_C = CW'(DEPTH / 2);

  logic [FLAG_W-1:0] base;

  always_comb begin
    base          = '0;
    base[FL_ACT]  = 1'b1;
    base[FL_FULL] = (count_i == FULL_C);
    base[FL_EMP]  = (count_i == '0);
    base[FL_AVL]  = (count_i != '0);
    tx_o = '0;
    rx_o = '0;
    if (live_i) begin
      if (dir_rx_i) begin
        rx_o         = base;
        rx_o[FL_THR] = (count_i >= HALF_C);
      end else begin
        tx_o         = base;
        tx_o[FL_THR] = (count_i <= HALF_C);
      end
    end
  end
endmodule

// File: rtl/card_fifo_engine.sv
module card_fifo_engine
  import cfe_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int W     = 32,
  parameter int LEN_W = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr_i,
  input  logic              ctrl_en_i,
  input  logic              ctrl_rx_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              host_push_i,
  input  logic [W-1:0]      host_wdata_i,
  input  logic              host_pop_i,
  output logic [W-1:0]      host_rdata_o,
  input  logic              crd_rx_valid_i,
  input  logic [7:0]        crd_rx_byte_i,
  output logic              crd_rx_ready_o,
  output logic              crd_tx_valid_o,
  output logic [7:0]        crd_tx_byte_o,
  input  logic              crd_tx_ready_i,
  output logic              busy_o,
  output logic [LEN_W-1:0]  remain_o,
  output logic              data_end_o,
  output logic              block_end_o,
  output logic [FLAG_W-1:0] tx_flags_o,
  output logic [FLAG_W-1:0] rx_flags_o,
  output logic              ovf_o
);
  logic             en_q, en_d, rx_q, rx_d, end_q, end_d, ovf_q, ovf_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic             rem_nz, start, rx_take, tx_take, byte_fire;
  logic             f_push, f_pop, f_full, f_empty, f_drop;
  logic [W-1:0]     f_wdata, f_rdata, pk_word;
  logic [CW-1:0]    f_count;
  logic             pk_push, up_pop, up_hold, host_push_ok;

  assign rem_nz = (rem_q != '0);
  assign start  = ctrl_wr_i & ctrl_en_i;

  assign crd_rx_ready_o = en_q & rx_q & rem_nz & ~f_full & ~ctrl_wr_i;
  assign crd_tx_valid_o = en_q & ~rx_q & rem_nz & (up_hold | ~f_empty) & ~ctrl_wr_i;
  assign rx_take   = crd_rx_ready_o & crd_rx_valid_i;
  assign tx_take   = crd_tx_valid_o & crd_tx_ready_i;
  assign byte_fire = rx_take | tx_take;

  assign host_push_ok = host_push_i & en_q & ~rx_q & rem_nz;
  assign f_push  = pk_push | host_push_ok;
  assign f_wdata = rx_q ? pk_word : host_wdata_i;
  assign f_pop   = (host_pop_i & rx_q) | up_pop;

  cfe_word_fifo #(.DEPTH(DEPTH), .W(W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_i(f_push), .wdata_i(f_wdata),
    .pop_i(f_pop), .rdata_o(f_rdata), .count_o(f_count),
    .full_o(f_full), .empty_o(f_empty), .drop_o(f_drop)
  );

  cfe_rx_packer #(.W(W)) u_pack (
    .clk(clk), .rst_n(rst_n), .clr_i(start), .take_i(rx_take),
    .last_i(rem_q == LEN_W'(1)), .byte_i(crd_rx_byte_i),
    .push_o(pk_push), .word_o(pk_word)
  );

  cfe_tx_unpacker #(.W(W)) u_unpack (
    .clk(clk), .rst_n(rst_n), .clr_i(start), .take_i(tx_take),
    .head_i(f_rdata), .pop_o(up_pop), .holding_o(up_hold),
    .byte_o(crd_tx_byte_o)
  );

  cfe_flag_gen #(.DEPTH(DEPTH)) u_flags (
    .count_i(f_count), .live_i(en_q & (rem_nz | ~f_empty)),
    .dir_rx_i(rx_q), .tx_o(tx_flags_o), .rx_o(rx_flags_o)
  );

  always_comb begin
    en_d  = en_q;
    rx_d  = rx_q;
    rem_d = rem_q;
    end_d = end_q;
    ovf_d = ovf_q | f_drop;
    if (ctrl_wr_i) begin
      en_d = ctrl_en_i;
      rx_d = ctrl_rx_i;
      if (ctrl_en_i) begin
        rem_d = len_i;
        end_d = 1'b0;
      end
    end else begin
      if (byte_fire) rem_d = rem_q - LEN_W'(1);
      if (en_q && !rem_nz) begin
        end_d = 1'b1;
        if (f_empty) en_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      rx_q  <= 1'b0;
      rem_q <= '0;
      end_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      rx_q  <= rx_d;
      rem_q <= rem_d;
      end_q <= end_d;
      ovf_q <= ovf_d;
    end
  end

  assign host_rdata_o = f_rdata;
  assign busy_o       = en_q;
  assign remain_o     = rem_q;
  assign data_end_o   = end_q;
  assign block_end_o  = end_q;
  assign ovf_o        = ovf_q;

  p_start_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (remain_o == $past(len_i)));
  p_byte_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_fire |=> (remain_o == $past(remain_o) - LEN_W'(1)));
  p_idle_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && remain_o == '0 && f_empty && !ctrl_wr_i) |=>
      (!busy_o && tx_flags_o == '0 && rx_flags_o == '0));
  p_one_group_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !((tx_flags_o != '0) && (rx_flags_o != '0)));
  p_rx_stall_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flags_o[FL_FULL]) |-> !crd_rx_ready_o);
  p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o);
  p_stop_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr_i && !ctrl_en_i) |=> (!busy_o && remain_o == $past(remain_o)));
endmodule

// File: tb/card_fifo_engine_bench.sv
module card_fifo_engine_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctrl_wr = 0, ctrl_en = 0, ctrl_rx = 0;
  logic [15:0] len = 0;
  logic host_push = 0, host_pop = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  logic rx_valid = 0, rx_ready, tx_valid, tx_ready = 0;
  logic [7:0] rx_byte = 0, tx_byte;
  logic busy, data_end, block_end, ovf;
  logic [15:0] remain;
  logic [4:0] tx_flags, rx_flags;

  int n_chk = 0, n_fail = 0;
  logic [7:0]  rb  [256];
  logic [31:0] wtx [64];

  always #(CLK_P/2) clk = ~clk;

  card_fifo_engine u_card_fifo_engine (
    .clk(clk), .rst_n(rst_n), .ctrl_wr_i(ctrl_wr), .ctrl_en_i(ctrl_en),
    .ctrl_rx_i(ctrl_rx), .len_i(len), .host_push_i(host_push),
    .host_wdata_i(host_wdata), .host_pop_i(host_pop), .host_rdata_o(host_rdata),
    .crd_rx_valid_i(rx_valid), .crd_rx_byte_i(rx_byte), .crd_rx_ready_o(rx_ready),
    .crd_tx_valid_o(tx_valid), .crd_tx_byte_o(tx_byte), .crd_tx_ready_i(tx_ready),
    .busy_o(busy), .remain_o(remain), .data_end_o(data_end), .block_end_o(block_end),
    .tx_flags_o(tx_flags), .rx_flags_o(rx_flags), .ovf_o(ovf)
  );

  task automatic report();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_flags(input int c, input bit rxdir);
    logic [4:0] f;
    f[0] = 1'b1;
    f[1] = rxdir ? (c >= 8) : (c <= 8);
    f[2] = (c == 16);
    f[3] = (c == 0);
    f[4] = (c != 0);
    return f;
  endfunction

  function automatic logic [31:0] pack_word(input int k, input int n);
    logic [31:0] w = '0;
    for (int b = 0; b < 4; b++)
      if (4*k + b < n) w[8*b +: 8] = rb[4*k + b];
    return w;
  endfunction

  task automatic start(input bit en, input bit rxd, input int n);
    @(negedge clk);
    ctrl_wr = 1; ctrl_en = en; ctrl_rx = rxd; len = 16'(n);
    @(negedge clk);
    ctrl_wr = 0; ctrl_en = 0;
  endtask

  task automatic check_done(input string tag);
    @(negedge clk); @(negedge clk); #1;
    check({tag, " R7 busy"}, {31'd0, busy}, 32'd0);
    check({tag, " R6 end"}, {30'd0, data_end, block_end}, 32'd3);
    check({tag, " R5 remain"}, {16'd0, remain}, 32'd0);
    check({tag, " R7 flags"}, {22'd0, tx_flags, rx_flags}, 32'd0);
  endtask

  // receive run: bytes rb[0..n-1]; fill=1 fills before popping and checks flags
  task automatic rx_run(input int n, input int pv, input int pp, input bit fill);
    int acc = 0, popn = 0, nw = (n + 3) / 4, cnt, pw;
    start(1, 1, n);
    while (acc < n || popn < nw) begin
      pw  = acc / 4 + ((acc == n && (n % 4) != 0) ? 1 : 0);
      cnt = pw - popn;
      if (fill && (acc == n || cnt == 16)) begin
        #1;
        check("R8 rx flags", {27'd0, rx_flags}, {27'd0, exp_flags(cnt, 1)});
        check("R9 tx group quiet", {27'd0, tx_flags}, 32'd0);
        fill = 0;
      end
      rx_valid = fill ? 1'b1 : (($urandom % 100) < pv);
      rx_byte  = (acc < n) ? rb[acc] : 8'h00;
      host_pop = !fill && (($urandom % 100) < pp);
      #1;
      check("R3 rx ready", {31'd0, rx_ready}, {31'd0, (acc < n && cnt < 16)});
      if (host_pop)
        check("R2 rx word", host_rdata, (cnt > 0) ? pack_word(popn, n) : 32'd0);
      if (rx_ready && rx_valid) acc++;
      if (host_pop && cnt > 0) popn++;
      @(negedge clk);
      rx_valid = 0; host_pop = 0;
    end
    check_done("rx");
  endtask

  // transmit run: words wtx[]; fill=1 pushes before the card starts
  task automatic tx_run(input int n, input int pp, input int pr, input bit fill);
    int sent = 0, pushed = 0, need = (n + 3) / 4, cnt;
    for (int i = 0; i < need; i++) wtx[i] = $urandom;
    start(1, 0, n);
    while (sent < n) begin
      cnt = pushed - (sent + 3) / 4;
      if (fill && (pushed == need || cnt == 16)) begin
        #1;
        check("R8 tx flags", {27'd0, tx_flags}, {27'd0, exp_flags(cnt, 0)});
        check("R9 rx group quiet", {27'd0, rx_flags}, 32'd0);
        fill = 0;
      end
      host_push  = (pushed < need) && (cnt < 16) && (fill || (($urandom % 100) < pp));
      host_wdata = wtx[pushed];
      tx_ready   = fill ? 1'b0 : (($urandom % 100) < pr);
      #1;
      check("R4 tx valid", {31'd0, tx_valid}, {31'd0, ((sent % 4) != 0 || cnt > 0)});
      if (tx_valid && tx_ready) begin
        check("R4 tx byte", {24'd0, tx_byte}, (wtx[sent/4] >> (8*(sent % 4))) & 32'hFF);
        sent++;
      end
      if (host_push) pushed++;
      @(negedge clk);
      host_push = 0; tx_ready = 0;
    end
    check_done("tx");
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R7 reset busy", {31'd0, busy}, 32'd0);
    check("R7 reset flags", {22'd0, tx_flags, rx_flags}, 32'd0);
    check("R5 reset remain", {16'd0, remain}, 32'd0);
    check("R1 reset rdata", host_rdata, 32'd0);
    check("R11 reset ovf", {31'd0, ovf}, 32'd0);

    // R2 directed: 6 bytes, trailing partial word
    for (int i = 0; i < 6; i++) rb[i] = 8'(8'h11 * (i + 1));
    rx_run(6, 100, 100, 1);
    check("R2 packed word", pack_word(1, 6), 32'h0000_6655);
    // R1 empty pop returns zero
    @(negedge clk); host_pop = 1; #1;
    check("R1 empty read", host_rdata, 32'd0);
    @(negedge clk); host_pop = 0;

    // R3/R8 full receive buffer stall
    for (int i = 0; i < 80; i++) rb[i] = 8'($urandom);
    rx_run(80, 100, 60, 1);

    // R6/R7 zero length start
    start(1, 1, 0);
    check_done("zero-len");

    // R10 idle push is ignored: later transmit sends only its own words
    @(negedge clk); host_push = 1; host_wdata = 32'hDEAD_BEEF;
    @(negedge clk); host_push = 0;
    tx_run(7, 100, 100, 1);
    tx_run(40, 70, 50, 1);

    // R12 stop mid-transfer
    for (int i = 0; i < 8; i++) rb[i] = 8'(i + 1);
    start(1, 1, 8);
    rx_valid = 1; rx_byte = 8'h01;
    @(negedge clk); @(negedge clk);
    rx_valid = 0;
    ctrl_wr = 1; ctrl_en = 0; ctrl_rx = 1;
    @(negedge clk); ctrl_wr = 0; rx_valid = 1; #1;
    check("R12 ready after stop", {31'd0, rx_ready}, 32'd0);
    check("R12 busy after stop", {31'd0, busy}, 32'd0);
    check("R12 remain kept", {16'd0, remain}, 32'd6);
    @(negedge clk); rx_valid = 0;
    // drain the two partial bytes left in the buffer? none pushed; start fresh
    for (int r = 0; r < 12; r++) begin
      int n = 1 + ($urandom % 150);
      if (r % 2 == 0) begin
        for (int i = 0; i < n; i++) rb[i] = 8'($urandom);
        rx_run(n, 30 + ($urandom % 70), 30 + ($urandom % 70), r % 4 == 0);
      end else begin
        tx_run(n, 30 + ($urandom % 70), 30 + ($urandom % 70), r % 4 == 1);
      end
    end

    // R11 overflow: 17 pushes into a 16-word buffer
    start(1, 0, 100);
    for (int i = 0; i < 17; i++) begin
      wtx[i] = 32'hA000_0000 + 32'(i);
      @(negedge clk); host_push = 1; host_wdata = wtx[i];
    end
    @(negedge clk); host_push = 0; #1;
    check("R11 ovf set", {31'd0, ovf}, 32'd1);
    check("R8 tx full flags", {27'd0, tx_flags}, 32'b10101);
    for (int s = 0; s < 64; s++) begin
      tx_ready = 1; #1;
      check("R11 kept bytes", {24'd0, tx_byte}, (wtx[s/4] >> (8*(s % 4))) & 32'hFF);
      @(negedge clk);
    end
    tx_ready = 0; #1;
    check("R4 no data valid", {31'd0, tx_valid}, 32'd0);
    check("R5 remain left", {16'd0, remain}, 32'd36);
    check("R8 tx empty flags", {27'd0, tx_flags}, 32'b01011);
    check("R11 ovf sticky", {31'd0, ovf}, 32'd1);

    report();
    $finish;
  end
endmodule